// File: doc/BRIEF.md
# Vectored Two-Level Priority Interrupt Controller

This block collects interrupt requests from thirteen maskable sources, a non-maskable watchdog request and a software break. For each maskable source it keeps a pending flag, a mask bit and a priority-group bit. Each cycle it picks one winner and presents that winner's vector address to the processor. Four of the maskable sources come from external pins through edge detectors. Three of those detectors have a programmable polarity. The fourth always reacts to a falling edge.

Acceptance of maskable requests depends on a global enable and on two in-service bits, one for each priority group. Software reads and writes all of this state through a small register port. The processor takes a request with a one-cycle acknowledge. The acknowledge clears the request that won, drops the global enable and records which group is now in service. Instruction execution, stacking and the return from service stay outside the block.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the flags, priority bits, edge configuration and status are 0, every mask bit is 1, and irq_o is low.
- R2: Source indices run 0 watchdog interval, 1..4 external pins 0..3, 5 serial 0, 6 serial 1, 7 watch timer, 8 16-bit timer, 9 8-bit timer 1, 10 8-bit timer 2, 11 A/D done, 12 key scan. int_req_i[0] feeds source 0 and int_req_i[k] feeds source k+4 for k=1..8. A one-cycle high on a request line sets its flag after the next clock edge.
- R3: A maskable winner with index i gets vector 0x0004 + 2*i, so the vectors run from 0x0004 to 0x001C.
- R4: A flag whose mask bit is 1 is still set by its request but is never chosen.
- R5: A high-group source can be accepted only when enable=1 and hi-service=0. A low-group source also needs lo-service=0.
- R6: A rising edge on nmi_i latches a non-maskable request. That request wins over everything, ignores enable and the service bits, uses vector 0x0004, and is not raised again while nmi_i simply stays high.
- R7: A pulse on brk_i latches a software break with vector 0x003E. The break ignores enable and loses only to the non-maskable request.
- R8: An acknowledge (ack_i high while irq_o is high) clears the winning flag or latch and clears enable. A maskable winner also sets hi-service if it is in the high group, or lo-service if it is in the low group.
- R9: Among the eligible pending flags, any high-group source beats every low-group source. Within one group the lowest index wins.
- R10: Edge register bits [2n+1:2n] set the edge for pin n (n=0..2): 00 falling, 01 rising, 10 or 11 both. Pin 3 reacts only to a falling edge.
- R11: Register map by reg_addr_i: 0 flags[12:0] (the write value replaces them), 1 mask[12:0], 2 priority[12:0] (1 = high group), 3 edge configuration[5:0], 4 status (bit0 enable, bit1 hi-service, bit2 lo-service). Reads return the current values, with unused bits and addresses reading as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| int_req_i | input | 9 | Internal request pulses (watchdog interval and sources 5..12) |
| pin_i | input | 4 | External interrupt pins 0..3 |
| nmi_i | input | 1 | Non-maskable watchdog request, rising-edge sensitive |
| brk_i | input | 1 | Software break pulse |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational) |
| irq_o | output | 1 | A request is ready for the processor |
| vec_o | output | 16 | Vector address of the current winner |
| ack_i | input | 1 | Processor acknowledge |

## Verification
The hardest case to reach is three kinds of request pending together: a non-maskable request arriving while a break is already latched, followed by acknowledges that must peel them off in order and leave nothing behind while nmi_i is still held high. The bench builds this by pulsing brk_i with enable off, then pulsing nmi_i, then acknowledging twice. Arbitration with nested service is reached by writing the flag, mask, priority and status registers directly from a vector table, so every combination of group and service state is set up in one step. Each edge mode is driven by rising and falling all four pins together under two different edge configurations.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NPIN = 4,
  parameter int NINT = 9,
  parameter int VW   = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NINT-1:0] int_req_i,
  input  logic [NPIN-1:0] pin_i,
  input  logic            nmi_i,
  input  logic            brk_i,
  input  logic            reg_we_i,
  input  logic [2:0]      reg_addr_i,
  input  logic [15:0]     reg_wdata_i,
  output logic [15:0]     reg_rdata_o,
  output logic            irq_o,
  output logic [VW-1:0]   vec_o,
  input  logic            ack_i
);
  localparam int NSRC = NINT + NPIN;
  localparam int IW   = $clog2(NSRC);
  localparam int CFGW = 2 * (NPIN - 1);
  localparam logic [VW-1:0] VEC_BASE = VW'(16'h0004);
  localparam logic [VW-1:0] VEC_BRK  = VW'(16'h003E);
  localparam logic [2:0] A_FLAG = 3'd0, A_MASK = 3'd1, A_PRIO = 3'd2,
                         A_EDGE = 3'd3, A_STAT = 3'd4;

  logic [NSRC-1:0] flag_q, mask_q, prio_q, set_v, clr_v, pend, cand_hi, cand_lo;
  logic [CFGW-1:0] cfg_q;
  logic [2*NPIN-1:0] cfg_ext;
  logic [NPIN-1:0] pin_q;
  logic pin_vld_q, nmi_q, nmi_pend_q, brk_pend_q;
  logic gie_q, svc_hi_q, svc_lo_q;
  logic hi_ok, lo_ok, win_vld, win_hi, take_brk, take_msk, acc;
  logic [IW-1:0] win_idx;

  assign cfg_ext = {2'b00, cfg_q};

  always_comb begin
    set_v = '0;
    set_v[0] = int_req_i[0];
    for (int k = 1; k < NINT; k++) set_v[k+NPIN] = int_req_i[k];
    for (int n = 0; n < NPIN; n++) begin
      logic [1:0] mode;
      logic rise, fall;
      mode = cfg_ext[2*n +: 2];
      rise = pin_i[n] & ~pin_q[n];
      fall = ~pin_i[n] & pin_q[n];
      set_v[1+n] = pin_vld_q & (mode[1] ? (rise | fall) : (mode[0] ? rise : fall));
    end
  end

  assign pend    = flag_q & ~mask_q;
  assign hi_ok   = gie_q & ~svc_hi_q;
  assign lo_ok   = hi_ok & ~svc_lo_q;
  assign cand_hi = pend & prio_q & {NSRC{hi_ok}};
  assign cand_lo = pend & ~prio_q & {NSRC{lo_ok}};

  always_comb begin
    win_vld = 1'b0;
    win_hi  = 1'b0;
    win_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (cand_lo[i]) begin win_vld = 1'b1; win_hi = 1'b0; win_idx = IW'(i); end
    for (int i = NSRC - 1; i >= 0; i--)
      if (cand_hi[i]) begin win_vld = 1'b1; win_hi = 1'b1; win_idx = IW'(i); end
  end

  assign take_brk = brk_pend_q & ~nmi_pend_q;
  assign take_msk = win_vld & ~nmi_pend_q & ~brk_pend_q;
  assign irq_o    = nmi_pend_q | brk_pend_q | win_vld;
  assign acc      = ack_i & irq_o;
  assign clr_v    = (acc && take_msk) ? (NSRC'(1) << win_idx) : '0;

  assign vec_o = nmi_pend_q ? VEC_BASE :
                 brk_pend_q ? VEC_BRK  :
                 VEC_BASE + (VW'(win_idx) << 1);

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_FLAG: reg_rdata_o[NSRC-1:0] = flag_q;
      A_MASK: reg_rdata_o[NSRC-1:0] = mask_q;
      A_PRIO: reg_rdata_o[NSRC-1:0] = prio_q;
      A_EDGE: reg_rdata_o[CFGW-1:0] = cfg_q;
      A_STAT: reg_rdata_o[2:0] = {svc_lo_q, svc_hi_q, gie_q};
      default: reg_rdata_o = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q      <= '0;
      pin_vld_q  <= 1'b0;
      nmi_q      <= 1'b0;
      nmi_pend_q <= 1'b0;
      brk_pend_q <= 1'b0;
      flag_q     <= '0;
      mask_q     <= '1;
      prio_q     <= '0;
      cfg_q      <= '0;
      gie_q      <= 1'b0;
      svc_hi_q   <= 1'b0;
      svc_lo_q   <= 1'b0;
    end else begin
      pin_q      <= pin_i;
      pin_vld_q  <= 1'b1;
      nmi_q      <= nmi_i;
      nmi_pend_q <= (nmi_pend_q & ~acc) | (nmi_i & ~nmi_q);
      brk_pend_q <= (brk_pend_q & ~(acc & take_brk)) | brk_i;
      flag_q     <= ((reg_we_i && reg_addr_i == A_FLAG) ? reg_wdata_i[NSRC-1:0]
                                                        : (flag_q & ~clr_v)) | set_v;
      if (reg_we_i && reg_addr_i == A_MASK) mask_q <= reg_wdata_i[NSRC-1:0];
      if (reg_we_i && reg_addr_i == A_PRIO) prio_q <= reg_wdata_i[NSRC-1:0];
      if (reg_we_i && reg_addr_i == A_EDGE) cfg_q  <= reg_wdata_i[CFGW-1:0];
      if (reg_we_i && reg_addr_i == A_STAT) begin
        gie_q    <= reg_wdata_i[0];
        svc_hi_q <= reg_wdata_i[1];
        svc_lo_q <= reg_wdata_i[2];
      end else if (acc) begin
        gie_q <= 1'b0;
        if (take_msk) begin
          svc_hi_q <= svc_hi_q | win_hi;
          svc_lo_q <= svc_lo_q | ~win_hi;
        end
      end
    end
  end

  assert_ack_drops_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !reg_we_i) |=> !gie_q);

  assert_winner_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && take_msk && !reg_we_i && !set_v[win_idx]) |=> !flag_q[$past(win_idx)]);

  assert_nmi_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_pend_q && !ack_i) |=> nmi_pend_q);

  assert_maskable_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !nmi_pend_q && !brk_pend_q) |-> (gie_q && !svc_hi_q));

  assert_vector_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (vec_o[0] == 1'b0 && vec_o <= VEC_BRK && vec_o >= VEC_BASE));

  assert_masked_never_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take_msk |-> !mask_q[win_idx]);
endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [8:0] int_req_i = '0;
  logic [3:0] pin_i = '0;
  logic nmi_i = 1'b0, brk_i = 1'b0, reg_we_i = 1'b0, ack_i = 1'b0;
  logic [2:0] reg_addr_i = '0;
  logic [15:0] reg_wdata_i = '0, reg_rdata_o, vec_o;
  logic irq_o;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  prio_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .int_req_i(int_req_i), .pin_i(pin_i),
    .nmi_i(nmi_i), .brk_i(brk_i), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .irq_o(irq_o),
    .vec_o(vec_o), .ack_i(ack_i));

  localparam int NV = 10;
  localparam logic [12:0] T_FLG [NV] = '{13'h1FFF, 13'h1FFF, 13'h1800, 13'h1800, 13'h1FFF,
                                        13'h0120, 13'h0120, 13'h0120, 13'h1FFF, 13'h0040};
  localparam logic [12:0] T_MSK [NV] = '{13'h0000, 13'h0001, 13'h0000, 13'h0000, 13'h0000,
                                        13'h0000, 13'h0000, 13'h0000, 13'h1FFF, 13'h0000};
  localparam logic [12:0] T_PRI [NV] = '{13'h0000, 13'h0000, 13'h1000, 13'h0000, 13'h0000,
                                        13'h0100, 13'h0000, 13'h0100, 13'h0000, 13'h1FFF};
  localparam logic [2:0]  T_STA [NV] = '{3'd1, 3'd1, 3'd1, 3'd1, 3'd0, 3'd5, 3'd5, 3'd3, 3'd1, 3'd1};
  localparam logic        T_IRQ [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1};
  localparam logic [15:0] T_VEC [NV] = '{16'h0004, 16'h0006, 16'h001C, 16'h001A, 16'h0000,
                                        16'h0014, 16'h0000, 16'h0000, 16'h0000, 16'h0010};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    reg_addr_i = a; #1; d = reg_rdata_o;
  endtask

  task automatic ack();
    ack_i = 1'b1; @(negedge clk); ack_i = 1'b0;
  endtask

  initial begin
    logic [15:0] r;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(3'd1, r); chk("R1 mask reset", r, 16'h1FFF);
    rd(3'd0, r); chk("R1 flags reset", r, 0);
    rd(3'd4, r); chk("R1 status reset", r, 0);
    rd(3'd3, r); chk("R1 edge reset", r, 0);
    chk("R1 irq reset", irq_o, 0);

    // R9 R5 R3 R4 arbitration table
    for (int v = 0; v < NV; v++) begin
      wr(3'd1, {3'b0, T_MSK[v]});
      wr(3'd2, {3'b0, T_PRI[v]});
      wr(3'd0, {3'b0, T_FLG[v]});
      wr(3'd4, {13'b0, T_STA[v]});
      chk($sformatf("R9 R5 table %0d irq", v), irq_o, T_IRQ[v]);
      if (T_IRQ[v]) chk($sformatf("R3 R9 table %0d vec", v), vec_o, T_VEC[v]);
    end

    // R2 request pulse, R8 low-group ack
    wr(3'd1, 0); wr(3'd2, 0); wr(3'd0, 0); wr(3'd4, 1);
    int_req_i[8] = 1'b1; @(negedge clk); int_req_i[8] = 1'b0;
    rd(3'd0, r); chk("R2 key scan flag", r, 16'h1000);
    chk("R3 key scan vec", vec_o, 16'h001C);
    ack();
    rd(3'd0, r); chk("R8 flag cleared", r, 0);
    rd(3'd4, r); chk("R8 low ack status", r, 16'h0004);
    chk("R8 irq idle", irq_o, 0);

    // R8 high-group ack
    wr(3'd2, 16'h0002); wr(3'd0, 16'h0002); wr(3'd4, 1);
    chk("R3 pin0 vec", vec_o, 16'h0006);
    ack();
    rd(3'd4, r); chk("R8 high ack status", r, 16'h0002);

    // R4 masked request still sets its flag
    wr(3'd4, 1); wr(3'd0, 0); wr(3'd1, 16'h0020);
    int_req_i[1] = 1'b1; @(negedge clk); int_req_i[1] = 1'b0;
    rd(3'd0, r); chk("R4 masked flag set", r, 16'h0020);
    chk("R4 masked no irq", irq_o, 0);

    // R10 edge modes
    wr(3'd4, 0); wr(3'd1, 0); wr(3'd3, 16'h0021); wr(3'd0, 0);
    pin_i = 4'hF; @(negedge clk);
    rd(3'd0, r); chk("R10 rise edges", r, 16'h000A);
    wr(3'd0, 0);
    pin_i = 4'h0; @(negedge clk);
    rd(3'd0, r); chk("R10 fall edges", r, 16'h001C);
    wr(3'd3, 16'h0015); wr(3'd0, 0);
    pin_i = 4'hF; @(negedge clk);
    rd(3'd0, r); chk("R10 all rise pin3 quiet", r, 16'h000E);
    wr(3'd0, 0);
    pin_i = 4'h0; @(negedge clk);
    rd(3'd0, r); chk("R10 pin3 falling only", r, 16'h0010);
    wr(3'd0, 0);

    // R7 break, R6 non-maskable precedence
    brk_i = 1'b1; @(negedge clk); brk_i = 1'b0;
    chk("R7 brk irq", irq_o, 1);
    chk("R7 brk vec", vec_o, 16'h003E);
    nmi_i = 1'b1; @(negedge clk);
    chk("R6 nmi vec over brk", vec_o, 16'h0004);
    ack();
    chk("R7 brk after nmi", vec_o, 16'h003E);
    ack();
    chk("R6 no retrigger on level", irq_o, 0);
    @(negedge clk);
    chk("R6 still idle", irq_o, 0);
    wr(3'd4, 3'd2);
    nmi_i = 1'b0; @(negedge clk); nmi_i = 1'b1; @(negedge clk);
    chk("R6 nmi ignores service", irq_o, 1);
    rd(3'd4, r); chk("R11 status readback", r, 16'h0002);
    ack();
    rd(3'd4, r); chk("R8 nmi ack keeps service", r, 16'h0002);
    chk("R6 cleared", irq_o, 0);

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule